// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block gathers up to eight interrupt request lines and presents them to a processor. It has one interrupt output and a vectored acknowledge. Software reaches it over a byte-wide register port with a one-bit address, a chip select and separate read and write strobes. Software first runs a short initialisation word sequence. After that, operation words set the mask, retire served interrupts, and choose which status register a read returns.

Each input is sampled either on its rising edge or by its level. The choice is made per input through a configuration input, and a zero means edge. Pending, unmasked requests compete under a fixed priority in which input 0 wins. The interrupt output rises only when the winner outranks everything already in service. A one-cycle acknowledge moves the winner into the in-service register and loads the vector output with the aligned base plus the input number.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the interrupt output is low, the vector output is 0x00, and a read at address 1 returns 0xFF.
- R2: A write at address 0 with data bit 4 set starts a new initialisation. It sets the mask to 0xFF, empties the in-service register, discards latched edges, and makes address-0 reads return the request register.
- R3: The second initialisation word, written at address 1, sets the vector base with its low 3 bits forced to zero. After an acknowledge, the vector output equals that base plus the winning input number.
- R4: The third initialisation word is expected only when bit 1 of the first word is clear. The fourth word is expected only when bit 0 of the first word is set. The address-1 write after the last expected word loads the mask.
- R5: Once initialisation is complete, an address-1 write loads the mask and an address-1 read returns it. A set mask bit keeps that input from raising the interrupt.
- R6: Among pending, unmasked inputs, the lowest-numbered one wins.
- R7: An edge-mode input latches a request on a low-to-high transition. The acknowledge clears that latch, and an input held high does not request again.
- R8: A level-mode input's request bit follows the live input and is not cleared by acknowledge.
- R9: The interrupt output is high only while the winning request outranks every in-service bit. Lower or equal requests wait until end-of-interrupt.
- R10: An address-0 write with bits 4 and 3 clear and bits 7..5 equal to 001 (0x20) clears the lowest-numbered in-service bit. Other values of bits 7..5 have no effect.
- R11: An address-0 write with bit 4 clear and bit 3 set updates the read selector when bit 1 is set. A value of 0x0A selects the request register and 0x0B the in-service register. With bit 1 clear the selector is unchanged.
- R12: Until initialisation completes, the interrupt output stays low, the mask reads 0xFF, and an acknowledge leaves the vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| req_in | input | NIN | Interrupt request inputs |
| lvl_mode | input | NIN | Per-input detection mode, 1 = level, 0 = edge |
| irq | output | 1 | Interrupt to the processor |
| ack | input | 1 | One-cycle acknowledge pulse |
| vec | output | 8 | Vector of the last acknowledged input |

## Verification
The bench builds the block with NIN left at 8, so every input index from 0 to 7 is reachable. That includes the case where the input number fills all three low bits of the vector, base plus 7. The full width also allows the masking, priority and nesting cases to put a high-numbered request behind a lower-numbered in-service bit. Three different first-word codes cover every length the initialisation sequence can take.

// File: rtl/irq_ctrl8.sv
module irq_ctrl8 #(
  parameter int NIN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs,
  input  logic           wr,
  input  logic           rd,
  input  logic           addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  input  logic [NIN-1:0] req_in,
  input  logic [NIN-1:0] lvl_mode,
  output logic           irq,
  input  logic           ack,
  output logic [7:0]     vec
);
  localparam int IW = (NIN > 1) ? $clog2(NIN) : 1;

  typedef enum logic [2:0] {S_OFF, S_W2, S_W3, S_W4, S_RUN} ist_t;

  ist_t           st;
  logic           want3, want4, rd_isr;
  logic [4:0]     base_hi;
  logic [NIN-1:0] imr, isr, edge_q, prev_q;
  logic [NIN-1:0] irr_eff, pend, isr_nx, edge_nx;
  logic [IW-1:0]  win, isr_top;

  function automatic logic [IW-1:0] low_idx(input logic [NIN-1:0] v);
    low_idx = '0;
    for (int i = NIN - 1; i >= 0; i--)
      if (v[i]) low_idx = IW'(i);
  endfunction

  wire wr_en  = cs & wr;
  wire w_icw1 = wr_en & ~addr & wdata[4];
  wire w_ocw2 = wr_en & ~addr & ~wdata[4] & ~wdata[3];
  wire w_ocw3 = wr_en & ~addr & ~wdata[4] & wdata[3];
  wire w_a1   = wr_en & addr;
  wire run    = (st == S_RUN);
  wire eoi    = w_ocw2 & (wdata[7:5] == 3'b001);

  assign irr_eff = (lvl_mode & req_in) | (~lvl_mode & edge_q);
  assign pend    = irr_eff & ~imr;
  assign win     = low_idx(pend);
  assign isr_top = low_idx(isr);
  assign irq     = run & (|pend) & (~(|isr) | (win < isr_top));

  wire take = ack & irq;

  always_comb begin
    isr_nx = isr;
    if (eoi && (|isr)) isr_nx[isr_top] = 1'b0;
    if (take) isr_nx[win] = 1'b1;
    edge_nx = edge_q | (req_in & ~prev_q);
    if (take) edge_nx[win] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_OFF;
      want3   <= 1'b0;
      want4   <= 1'b0;
      rd_isr  <= 1'b0;
      base_hi <= '0;
      imr     <= '1;
      isr     <= '0;
      edge_q  <= '0;
      prev_q  <= '0;
      vec     <= '0;
    end else begin
      prev_q <= req_in;
      if (w_icw1) begin
        st     <= S_W2;
        want3  <= ~wdata[1];
        want4  <= wdata[0];
        rd_isr <= 1'b0;
        imr    <= '1;
        isr    <= '0;
        edge_q <= '0;
      end else begin
        edge_q <= edge_nx;
        isr    <= isr_nx;
        if (w_ocw3 && wdata[1]) rd_isr <= wdata[0];
        if (w_a1) begin
          case (st)
            S_W2: begin
              base_hi <= wdata[7:3];
              st <= want3 ? S_W3 : (want4 ? S_W4 : S_RUN);
            end
            S_W3:    st <= want4 ? S_W4 : S_RUN;
            S_W4:    st <= S_RUN;
            S_RUN:   imr <= wdata[NIN-1:0];
            default: st <= st;
          endcase
        end
        if (take) vec <= {base_hi, 3'b000} | 8'(win);
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      if (addr)        rdata = 8'(imr);
      else if (rd_isr) rdata = 8'(isr);
      else             rdata = 8'(irr_eff);
    end
  end

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    w_icw1 |=> (imr == '1 && isr == '0 && !irq)); // R2
  AST_UNINIT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RUN) |-> (imr == '1 && !irq)); // R12
  AST_ACK_GROWS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !eoi && !w_icw1) |=> ($countones(isr) == $past($countones(isr)) + 1)); // R9
  AST_EOI_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && (|isr) && !take) |=> ($countones(isr) + 1 == $past($countones(isr)))); // R10
  AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !w_icw1) |=> (vec[7:3] == $past(base_hi))); // R3
  AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !lvl_mode[win] && !w_icw1) |=> !edge_q[$past(win)]); // R7
endmodule

// File: tb/sim_irq_ctrl8.sv
`timescale 1ns/1ps
module sim_irq_ctrl8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, wr = 0, rd = 0, addr = 0, ack = 0;
  logic [7:0] wdata = 0, req_in = 0, lvl_mode = 0;
  logic [7:0] rdata, vec;
  logic irq;
  int checks = 0, fails = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  irq_ctrl8 #(.NIN(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .req_in(req_in), .lvl_mode(lvl_mode),
    .irq(irq), .ack(ack), .vec(vec));

  typedef struct packed {
    logic [7:0] mask;
    logic [7:0] req;
    logic       exp_irq;
    logic [7:0] exp_vec;
  } vrow_t;

  localparam vrow_t TBL [7] = '{
    '{8'h00, 8'h01, 1'b1, 8'h40},
    '{8'h00, 8'h0C, 1'b1, 8'h42},
    '{8'h04, 8'h0C, 1'b1, 8'h43},
    '{8'hFF, 8'h80, 1'b0, 8'h00},
    '{8'h00, 8'h80, 1'b1, 8'h47},
    '{8'h7F, 8'hFF, 1'b1, 8'h47},
    '{8'h00, 8'hA0, 1'b1, 8'h45}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wreg(input logic a, input logic [7:0] d);
    cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic rreg(input logic a, output logic [7:0] v);
    cs = 1; rd = 1; addr = a;
    #1 v = rdata;
    cs = 0; rd = 0;
  endtask

  task automatic do_ack();
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  task automatic init_std();
    wreg(0, 8'h11); wreg(1, 8'h47); wreg(1, 8'h04); wreg(1, 8'h01);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 irq after reset", 8'(irq), 8'h00);
    chk("R1 vec after reset", vec, 8'h00);
    rreg(1, v); chk("R1 mask after reset", v, 8'hFF);

    for (int i = 0; i < 7; i++) begin
      req_in = 0; tick();
      init_std();
      wreg(1, TBL[i].mask);
      req_in = TBL[i].req;
      tick();
      chk("R5 R6 table irq", 8'(irq), 8'(TBL[i].exp_irq));
      if (TBL[i].exp_irq) begin
        do_ack();
        chk("R3 R6 table vec", vec, TBL[i].exp_vec);
        wreg(0, 8'h20);
      end
      req_in = 0; tick();
    end

    init_std();
    wreg(1, 8'h00);
    req_in[4] = 1; tick();
    chk("R7 edge raises irq", 8'(irq), 8'h01);
    do_ack();
    chk("R7 vec", vec, 8'h44);
    rreg(0, v); chk("R7 request cleared on ack", v, 8'h00);
    wreg(0, 8'h20); tick();
    chk("R7 held high no retrigger", 8'(irq), 8'h00);
    req_in = 0; tick();

    lvl_mode[3] = 1; req_in[3] = 1; tick();
    chk("R8 level irq", 8'(irq), 8'h01);
    do_ack();
    chk("R8 vec", vec, 8'h43);
    rreg(0, v); chk("R8 level stays after ack", v, 8'h08);
    req_in[3] = 0; tick();
    rreg(0, v); chk("R8 follows level low", v, 8'h00);
    wreg(0, 8'h20); lvl_mode = 0; tick();

    req_in[5] = 1; tick(); do_ack();
    req_in[6] = 1; tick();
    chk("R9 lower request waits", 8'(irq), 8'h00);
    req_in[1] = 1; tick();
    chk("R9 higher request nests", 8'(irq), 8'h01);
    do_ack();
    chk("R9 nested vec", vec, 8'h41);
    wreg(0, 8'h0B);
    rreg(0, v); chk("R11 isr select", v, 8'h22);
    wreg(0, 8'h40);
    rreg(0, v); chk("R10 other OCW2 ignored", v, 8'h22);
    wreg(0, 8'h20);
    rreg(0, v); chk("R10 eoi clears top", v, 8'h20);
    chk("R9 still blocked by 5", 8'(irq), 8'h00);
    wreg(0, 8'h20);
    rreg(0, v); chk("R10 eoi empties isr", v, 8'h00);
    chk("R9 released after eoi", 8'(irq), 8'h01);
    do_ack();
    chk("R9 vec 6", vec, 8'h46);
    wreg(0, 8'h20);
    req_in = 0; tick();

    wreg(1, 8'hFF);
    lvl_mode[2] = 1; req_in[2] = 1; tick();
    rreg(0, v); chk("R11 isr reads zero", v, 8'h00);
    wreg(0, 8'h08);
    rreg(0, v); chk("R11 bit1 clear keeps select", v, 8'h00);
    wreg(0, 8'h0A);
    rreg(0, v); chk("R11 irr select", v, 8'h04);
    req_in = 0; lvl_mode = 0; wreg(1, 8'h00);

    lvl_mode[7] = 1; req_in[7] = 1; tick();
    req_in[0] = 1; tick(); do_ack();
    wreg(0, 8'h0B);
    rreg(0, v); chk("R2 isr before restart", v, 8'h01);
    wreg(0, 8'h13);
    rreg(1, v); chk("R2 mask restored", v, 8'hFF);
    rreg(0, v); chk("R2 selector back to irr", v, 8'h80);
    chk("R12 no irq during init", 8'(irq), 8'h00);
    wreg(1, 8'h88); wreg(1, 8'h01);
    rreg(1, v); chk("R4 no third word", v, 8'hFF);
    wreg(1, 8'h7F);
    rreg(1, v); chk("R4 R5 mask after word4", v, 8'h7F);
    chk("R5 unmasked level 7", 8'(irq), 8'h01);
    do_ack();
    chk("R3 base 0x88 plus 7", vec, 8'h8F);
    wreg(0, 8'h20);
    req_in = 0; lvl_mode = 0; tick();

    wreg(0, 8'h12); wreg(1, 8'h20); wreg(1, 8'h5A);
    rreg(1, v); chk("R4 two-word sequence", v, 8'h5A);

    wreg(0, 8'h11); wreg(1, 8'h40); wreg(1, 8'h04);
    rreg(1, v); chk("R4 R12 word4 pending", v, 8'hFF);
    req_in[0] = 1; tick();
    chk("R12 irq low before done", 8'(irq), 8'h00);
    do_ack();
    chk("R12 ack ignored before done", vec, 8'h8F);
    wreg(1, 8'h01); wreg(1, 8'h00);
    chk("R4 ready after word4", 8'(irq), 8'h01);
    req_in = 0; tick();

    finish_run();
  end
endmodule